// File: doc/BRIEF.md
# Clock-Gated One-of-Eight Strobe Decoder

This block turns a small binary select field into a set of active-high, one-hot port strobes. It is used to steer I/O commands from a small processor to peripheral ports. The processor's 3-bit command field drives the select lines. Strobe 0 is left spare, and strobes 1 to 7 each pick one input or output device directly.

A strobe may be high only inside a timing window. The window opens when a first timing pulse falls and closes when a second timing pulse falls. Between those two events the window keeps its state. A chip-enable input gates every strobe, so one decoder's strobe can feed the chip enable of the next stage. That allows several levels of port selection.

All inputs are sampled by one system clock. Each timing pulse passes through a synchroniser followed by a falling-edge detector. The select and chip-enable lines are registered once and then decoded.

Top module: `strobe_decoder`

## Requirements
- R1: After a synchronous active-high reset, every bit of `strobe_o` is low. It stays low until a falling edge of `open_pulse` is seen, even if both pulse lines are held high.
- R2: When the window is open and chip enable is high, exactly one strobe is high. Bit k of `strobe_o` is high when the registered `sel_in` equals the unsigned binary value k.
- R3: When `chip_en` is low at a rising clock edge, all strobes are low after that edge. This holds whatever the select and pulse inputs are.
- R4: A high-to-low change of `open_pulse` opens the window. The strobe first appears after the (SYNC_STAGES+1)-th rising clock edge that follows the change. With the defaults that is the third edge, and the window is still closed after the second.
- R5: A high-to-low change of `close_pulse` closes the window with the same latency as R4. With the defaults the third edge after the change clears all strobes.
- R6: Rising edges and steady levels on either pulse line leave the window state unchanged. This includes changes to `sel_in` while the window is closed, which keep every strobe low.
- R7: If the falling edges of both pulses are detected in the same clock cycle, the window ends closed. This is so whether it was open or closed before.
- R8: If `sel_in` changes while the window is open, the high strobe moves to the new index after one rising clock edge. No cycle ever has more than one strobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| open_pulse | input | 1 | Timing pulse; its falling edge opens the window |
| close_pulse | input | 1 | Timing pulse; its falling edge closes the window |
| chip_en | input | 1 | Gates all strobes; feed from an upstream strobe to cascade |
| sel_in | input | SEL_W (3) | Binary index of the strobe to assert |
| strobe_o | output | 2**SEL_W (8) | One-hot active-high strobes |

## Verification
The bench builds the decoder with its defaults: SEL_W of 3, which gives eight strobes, and SYNC_STAGES of 2. With two synchroniser stages the open and close latency is exactly three clock edges. The bench checks the window at both the second and the third edge, so a latency that is off by one is caught. With eight outputs, random selects reach every index within a few dozen draws. The random window actions also produce falls of both pulses in one cycle, from both the open and the closed state.

// File: rtl/strobe_dec_pkg.sv
package strobe_dec_pkg;

    localparam int DEF_SEL_W       = 3;
    localparam int DEF_SYNC_STAGES = 2;

    // Falling edges seen on the two timing pulses in one clock cycle.
    typedef struct packed {
        logic open_fall;
        logic close_fall;
    } pulse_edges_t;

    // Command applied to the window state register.
    typedef enum logic [1:0] {
        WIN_HOLD  = 2'd0,
        WIN_OPEN  = 2'd1,
        WIN_CLOSE = 2'd2
    } win_cmd_e;

    // A close event overrides an open event in the same cycle.
    function automatic win_cmd_e resolve_cmd(input pulse_edges_t e);
        if (e.close_fall) begin
            return WIN_CLOSE;
        end
        if (e.open_fall) begin
            return WIN_OPEN;
        end
        return WIN_HOLD;
    endfunction

endpackage

// File: rtl/sdec_fall_detect.sv
module sdec_fall_detect #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic fall_o
);
    // Elements 0..STAGES-1 synchronise the pulse; element STAGES holds
    // the previous synchronised sample.
    logic [STAGES:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q[0] <= 1'b0;
        end else begin
            chain_q[0] <= pulse_in;
        end
    end

    for (genvar i = 1; i <= STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain_q[i] <= 1'b0;
            end else begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

endmodule

// File: rtl/sdec_window.sv
module sdec_window
    import strobe_dec_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  pulse_edges_t edges,
    output logic         win_o
);
    win_cmd_e cmd;

    assign cmd = resolve_cmd(edges);

    always_ff @(posedge clk) begin
        if (rst) begin
            win_o <= 1'b0;
        end else begin
            case (cmd)
                WIN_OPEN:  win_o <= 1'b1;
                WIN_CLOSE: win_o <= 1'b0;
                default:   win_o <= win_o;
            endcase
        end
    end

endmodule

// File: rtl/sdec_onehot.sv
module sdec_onehot #(
    parameter int SEL_W   = 3,
    localparam int NUM_OUT = 1 << SEL_W
) (
    input  logic [SEL_W-1:0]   sel,
    input  logic               gate,
    output logic [NUM_OUT-1:0] strobe
);
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
        localparam logic [SEL_W-1:0] IDX = SEL_W'(k);
        assign strobe[k] = gate && (sel == IDX);
    end

endmodule

// File: rtl/strobe_decoder.sv
module strobe_decoder
    import strobe_dec_pkg::*;
#(
    parameter int SEL_W       = DEF_SEL_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES,
    localparam int NUM_OUT    = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               open_pulse,
    input  logic               close_pulse,
    input  logic               chip_en,
    input  logic [SEL_W-1:0]   sel_in,
    output logic [NUM_OUT-1:0] strobe_o
);
    logic             open_fall;
    logic             close_fall;
    logic             win_q;
    logic             ce_q;
    logic [SEL_W-1:0] sel_q;
    pulse_edges_t     edges;

    sdec_fall_detect #(.STAGES(SYNC_STAGES)) u_open_det (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (open_pulse),
        .fall_o   (open_fall)
    );

    sdec_fall_detect #(.STAGES(SYNC_STAGES)) u_close_det (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (close_pulse),
        .fall_o   (close_fall)
    );

    assign edges = '{open_fall: open_fall, close_fall: close_fall};

    sdec_window u_window (
        .clk   (clk),
        .rst   (rst),
        .edges (edges),
        .win_o (win_q)
    );

    // Select and chip enable are sampled once; the decode is driven from
    // a single register so that at most one strobe can be high.
    always_ff @(posedge clk) begin
        if (rst) begin
            ce_q  <= 1'b0;
            sel_q <= '0;
        end else begin
            ce_q  <= chip_en;
            sel_q <= sel_in;
        end
    end

    sdec_onehot #(.SEL_W(SEL_W)) u_decode (
        .sel    (sel_q),
        .gate   (win_q && ce_q),
        .strobe (strobe_o)
    );

endmodule

// File: rtl/strobe_decoder_chk.sv
module strobe_decoder_chk #(
    parameter int SEL_W   = 3,
    localparam int NUM_OUT = 1 << SEL_W
) (
    input logic               clk,
    input logic               rst,
    input logic               chip_en,
    input logic [SEL_W-1:0]   sel_in,
    input logic [NUM_OUT-1:0] strobe_o,
    input logic               win_q,
    input logic               open_fall,
    input logic               close_fall
);
    assert_reset_low_R1: assert property (@(posedge clk)
        $past(rst) |-> (strobe_o == '0));

    assert_index_R2: assert property (@(posedge clk) disable iff (rst)
        (strobe_o != '0) |-> (strobe_o == (NUM_OUT'(1) << $past(sel_in))));

    assert_ce_gate_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(chip_en) |-> (strobe_o == '0));

    assert_open_R4: assert property (@(posedge clk) disable iff (rst)
        (open_fall && !close_fall) |=> win_q);

    assert_close_R7: assert property (@(posedge clk) disable iff (rst)
        close_fall |=> !win_q);

    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!open_fall && !close_fall) |=> $stable(win_q));

    assert_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));

endmodule

bind strobe_decoder strobe_decoder_chk #(.SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chip_en    (chip_en),
    .sel_in     (sel_in),
    .strobe_o   (strobe_o),
    .win_q      (win_q),
    .open_fall  (open_fall),
    .close_fall (close_fall)
);

// File: tb/sim_strobe_decoder.sv
`timescale 1ns/1ps
module sim_strobe_decoder;
    localparam int SEL_W   = 3;
    localparam int NUM_OUT = 8;
    localparam int LAT     = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               open_pulse = 1'b1;
    logic               close_pulse = 1'b1;
    logic               chip_en = 1'b1;
    logic [SEL_W-1:0]   sel_in = '0;
    logic [NUM_OUT-1:0] strobe_o;

    int checks = 0;
    int errors = 0;
    logic win_m = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    strobe_decoder u0 (
        .clk         (clk),
        .rst         (rst),
        .open_pulse  (open_pulse),
        .close_pulse (close_pulse),
        .chip_en     (chip_en),
        .sel_in      (sel_in),
        .strobe_o    (strobe_o)
    );

    function automatic logic [NUM_OUT-1:0] exp_strobe(input logic win,
            input logic ce, input logic [SEL_W-1:0] sel);
        return (win && ce) ? (NUM_OUT'(1) << sel) : '0;
    endfunction

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [NUM_OUT-1:0] exp);
        checks++;
        if (strobe_o !== exp || !$onehot0(strobe_o)) begin
            errors++;
            $display("FAIL %s: strobe_o=%b expected=%b at %0t", req, strobe_o, exp, $time);
        end
    endtask

    // Drop one or both pulses, return them high, then let the window settle.
    task automatic pulse_fall(input bit a, input bit b);
        if (a) open_pulse = 1'b0;
        if (b) close_pulse = 1'b0;
        step(1);
        open_pulse = 1'b1;
        close_pulse = 1'b1;
        step(LAT + 2);
        if (b) win_m = 1'b0;
        else if (a) win_m = 1'b1;
    endtask

    initial begin
        void'($urandom(32'hC0FFEE));
        chip_en = 1'b1;
        sel_in  = 3'd3;
        step(3);
        rst = 1'b0;
        step(1);
        check("R1 after reset", '0);
        step(5);
        check("R1 pulses high, no fall", '0);

        // Open latency
        open_pulse = 1'b0;
        step(2);
        check("R4 still closed after second edge", '0);
        step(1);
        check("R4 open after third edge", 8'b0000_1000);
        win_m = 1'b1;
        open_pulse = 1'b1;
        step(5);
        check("R6 rising open_pulse keeps window", 8'b0000_1000);

        // Select walk while open
        for (int k = 0; k < NUM_OUT; k++) begin
            sel_in = SEL_W'(k);
            step(1);
            check("R8 select moves in one edge", NUM_OUT'(1) << k);
        end

        // Chip enable gating
        chip_en = 1'b0;
        step(1);
        check("R3 chip enable low", '0);
        chip_en = 1'b1;
        sel_in = 3'd5;
        step(1);
        check("R2 chip enable restored", 8'b0010_0000);

        // Random select / chip enable while open
        for (int i = 0; i < 40; i++) begin
            sel_in  = SEL_W'($urandom);
            chip_en = 1'($urandom);
            step(1);
            check("R2/R3 random open", exp_strobe(win_m, chip_en, sel_in));
        end

        // Close latency
        chip_en = 1'b1;
        sel_in = 3'd6;
        step(1);
        close_pulse = 1'b0;
        step(2);
        check("R5 still open after second edge", 8'b0100_0000);
        step(1);
        check("R5 closed after third edge", '0);
        win_m = 1'b0;
        close_pulse = 1'b1;
        step(5);
        check("R6 rising close_pulse keeps closed", '0);
        sel_in = 3'd1;
        step(2);
        check("R6 select change while closed", '0);

        // Simultaneous falls
        pulse_fall(1'b1, 1'b1);
        check("R7 both fall from closed", '0);
        pulse_fall(1'b1, 1'b0);
        check("R4 reopen", 8'b0000_0010);
        pulse_fall(1'b1, 1'b1);
        check("R7 both fall from open", '0);

        // Random window actions
        for (int i = 0; i < 30; i++) begin
            int unsigned act;
            act = $urandom_range(0, 3);
            sel_in  = SEL_W'($urandom);
            chip_en = ($urandom_range(0, 3) != 0);
            pulse_fall(act == 1 || act == 3, act == 2 || act == 3);
            check("R2/R5/R7 random window", exp_strobe(win_m, chip_en, sel_in));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule